// File: doc/BRIEF.md
# Ethernet Receive Frame Gate

This block sits on the receive side of an Ethernet MAC and turns a raw byte stream into framed data for a downstream FIFO. It hunts for the preamble and start-of-frame delimiter, removes both, and forwards every following byte with one cycle of latency. The first forwarded byte carries a start marker and the byte presented with `rx_last` carries an end marker.

While the frame streams through, the block classifies the destination address as individual, group or broadcast. It compares individual addresses with a programmed station address, counts the frame length, and applies a per-window cap on accepted broadcast frames. It does not buffer frames. A frame that must be discarded is still forwarded, and its end byte carries an error marker, so the FIFO can roll back the frame.

The FCS is checked elsewhere. The result arrives on `rx_fcs_ok` together with the last byte.

Top module: `rx_frame_gate`

## Requirements
- R1: A frame is opened only by a byte 0xD5 that follows at least 7 consecutive 0x55 bytes. Any other sequence causes the block to ignore bytes up to and including the next `rx_last` byte, and it produces no output for them.
- R2: Every byte after the delimiter is output unchanged on `o_data` one clock after it is accepted. The first such byte has `o_sof`=1 and the byte accepted with `rx_last`=1 has `o_eof`=1.
- R3: A frame whose first destination byte has bit 0 set (group address) is never rejected by the address filter.
- R4: When `filt_en`=1, a frame with an individual destination that differs from `stn_addr` is marked with `o_err`. The first destination byte received is compared with `stn_addr[47:40]` and the last with `stn_addr[7:0]`. When `filt_en`=0, no address check is made.
- R5: A destination of six 0xFF bytes is classed as broadcast and is accepted without matching the station address.
- R6: A frame of fewer than 64 content bytes (counting from the first destination byte through the FCS) is marked with `o_err`. A frame of exactly 64 bytes is not marked for length.
- R7: The maximum length is 1518 bytes when `jumbo_en`=0 and 9600 bytes when `jumbo_en`=1. One byte more than the limit marks the frame with `o_err`.
- R8: `rx_fcs_ok`=0 on the last byte marks the frame with `o_err`.
- R9: When `bc_lim_en`=1, at most `bc_max` broadcast frames that pass all other checks are accepted per window of `bc_win` clocks. Further broadcast frames ending in that window are marked with `o_err`. The window counter restarts at reset.
- R10: `o_err` is set only on an end byte. A clock with `rx_valid`=0 produces no output byte and does not advance the frame.
- R11: After reset, `o_valid`, `o_sof`, `o_eof` and `o_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Last byte of the current frame |
| rx_fcs_ok | input | 1 | FCS good, sampled with `rx_last` |
| stn_addr | input | 48 | Station address, first byte on the line in bits 47:40 |
| filt_en | input | 1 | Enable the individual address filter |
| jumbo_en | input | 1 | Raise the length limit to the jumbo value |
| bc_lim_en | input | 1 | Enable the broadcast cap |
| bc_max | input | 8 | Broadcast frames allowed per window |
| bc_win | input | 16 | Window length in clocks |
| o_valid | output | 1 | Output byte valid |
| o_data | output | 8 | Output byte |
| o_sof | output | 1 | First byte of frame |
| o_eof | output | 1 | Last byte of frame |
| o_err | output | 1 | Frame rejected, on the end byte |

## Verification
The embedded assertions check four properties on every clock. Each output byte must equal the input byte from the previous clock. Markers appear only with a valid byte, and the error marker only on an end byte. Every end byte of a runt frame, or of a frame over the standard limit while jumbo mode is off, must carry the error marker. Other behaviours can only be shown by the bench's scenarios, because each depends on a whole sequence of bytes or clocks: address matching, group and broadcast bypass, preamble and delimiter rejection, FCS errors, stalls, and the broadcast cap across window boundaries.

// File: rtl/rx_frame_gate.sv
module rx_frame_gate #(
  parameter int MIN_LEN   = 64,
  parameter int MAX_STD   = 1518,
  parameter int MAX_JUMBO = 9600,
  parameter int LEN_W     = 14,
  parameter int BC_W      = 8,
  parameter int WIN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             rx_fcs_ok,
  input  logic [47:0]      stn_addr,
  input  logic             filt_en,
  input  logic             jumbo_en,
  input  logic             bc_lim_en,
  input  logic [BC_W-1:0]  bc_max,
  input  logic [WIN_W-1:0] bc_win,
  output logic             o_valid,
  output logic [7:0]       o_data,
  output logic             o_sof,
  output logic             o_eof,
  output logic             o_err
);
  localparam logic [LEN_W-1:0] LEN_TOP = '1;
  localparam logic [LEN_W-1:0] LMIN = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LSTD = LEN_W'(MAX_STD);
  localparam logic [LEN_W-1:0] LJMB = LEN_W'(MAX_JUMBO);

  typedef enum logic [1:0] {HUNT, FRAME, SKIP} st_t;
  st_t st;

  logic [2:0]       pre_cnt;
  logic [LEN_W-1:0] len;
  logic [47:0]      da_sh;
  logic             miss, nbc, grp;
  logic [WIN_W-1:0] wcnt;
  logic [BC_W-1:0]  bcnt;

  wire              in_da    = len < LEN_W'(6);
  wire [LEN_W-1:0]  len_n    = (len == LEN_TOP) ? len : len + 1'b1;
  wire              len_bad  = (len_n < LMIN) || (len_n > (jumbo_en ? LJMB : LSTD));
  wire              addr_rej = filt_en && !grp && miss;
  wire              base_bad = !rx_fcs_ok || len_bad || addr_rej;
  wire              thr_rej  = bc_lim_en && !nbc && (bcnt >= bc_max);
  wire              at_eof   = rx_valid && (st == FRAME) && rx_last;
  wire              bc_take  = at_eof && !nbc && !base_bad && !thr_rej;
  wire              wrap     = wcnt >= bc_win - 1'b1;
  wire [BC_W-1:0]   bc_inc   = (bc_take && bcnt != '1) ? BC_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HUNT;
      pre_cnt <= '0;
      len <= '0;
      da_sh <= '0;
      miss <= 1'b0;
      nbc <= 1'b0;
      grp <= 1'b0;
      wcnt <= '0;
      bcnt <= '0;
      o_valid <= 1'b0;
      o_data <= '0;
      o_sof <= 1'b0;
      o_eof <= 1'b0;
      o_err <= 1'b0;
    end else begin
      o_valid <= 1'b0;
      o_sof <= 1'b0;
      o_eof <= 1'b0;
      o_err <= 1'b0;
      wcnt <= wrap ? '0 : wcnt + 1'b1;
      bcnt <= wrap ? bc_inc : bcnt + bc_inc;
      if (rx_valid) begin
        case (st)
          HUNT: begin
            if (rx_last) pre_cnt <= '0;
            else if (rx_data == 8'h55) pre_cnt <= (pre_cnt == 3'd7) ? pre_cnt : pre_cnt + 1'b1;
            else if (rx_data == 8'hD5 && pre_cnt == 3'd7) begin
              st <= FRAME;
              pre_cnt <= '0;
              len <= '0;
              da_sh <= stn_addr;
              miss <= 1'b0;
              nbc <= 1'b0;
              grp <= 1'b0;
            end else begin
              st <= SKIP;
              pre_cnt <= '0;
            end
          end
          SKIP: if (rx_last) st <= HUNT;
          FRAME: begin
            o_valid <= 1'b1;
            o_data <= rx_data;
            o_sof <= (len == '0);
            len <= len_n;
            if (in_da) begin
              da_sh <= {da_sh[39:0], 8'h00};
              if (rx_data != da_sh[47:40]) miss <= 1'b1;
              if (rx_data != 8'hFF) nbc <= 1'b1;
              if (len == '0) grp <= rx_data[0];
            end
            if (rx_last) begin
              o_eof <= 1'b1;
              o_err <= base_bad || thr_rej;
              st <= HUNT;
            end
          end
          default: st <= HUNT;
        endcase
      end
    end
  end

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> o_data == $past(rx_data)) else $error("data path"); // R2

  AST_MARK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid |-> !o_sof && !o_eof && !o_err) else $error("marker without byte"); // R10

  AST_ERR_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    o_err |-> o_eof) else $error("error off end byte"); // R10

  AST_RUNT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (o_eof && len < LMIN) |-> o_err) else $error("runt passed"); // R6

  AST_LONG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (o_eof && len > LSTD && !$past(jumbo_en)) |-> o_err) else $error("oversize passed"); // R7
endmodule

// File: tb/rx_frame_gate_tb.sv
module rx_frame_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        rx_fcs_ok = 1'b0;
  logic [47:0] stn_addr = 48'h0A1B2C3D4E5F;
  logic        filt_en = 1'b1;
  logic        jumbo_en = 1'b0;
  logic        bc_lim_en = 1'b0;
  logic [7:0]  bc_max = 8'd1;
  logic [15:0] bc_win = 16'd1000;
  logic        o_valid, o_sof, o_eof, o_err;
  logic [7:0]  o_data;

  int vecs = 0;
  int bad = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_gate dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_fcs_ok(rx_fcs_ok), .stn_addr(stn_addr),
    .filt_en(filt_en), .jumbo_en(jumbo_en), .bc_lim_en(bc_lim_en),
    .bc_max(bc_max), .bc_win(bc_win), .o_valid(o_valid), .o_data(o_data),
    .o_sof(o_sof), .o_eof(o_eof), .o_err(o_err)
  );

  always @(negedge clk) begin
    if (rst_n && o_valid) begin
      vecs++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected output: got %h expected none (R1)", {o_sof, o_eof, o_err, o_data});
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({o_sof, o_eof, o_err, o_data} !== e) begin
          bad++;
          $display("FAIL %s: got sof/eof/err/data %h expected %h", t, {o_sof, o_eof, o_err, o_data}, e);
        end
      end
    end
  end

  function automatic logic [7:0] fbyte(input logic [47:0] da, input int i);
    if (i < 6) return da[47-8*i -: 8];
    if (i < 11) return 8'h02;
    if (i == 11) return 8'h01;
    return 8'((i * 7 + 3) & 255);
  endfunction

  function automatic bit model_err(input logic [47:0] da, input int n, input bit fcs, input bit thr);
    int lim;
    bit e;
    lim = jumbo_en ? 9600 : 1518;
    e = !fcs || n < 64 || n > lim || thr;
    if (filt_en && !da[40] && da != stn_addr) e = 1;
    return e;
  endfunction

  task automatic drive(input logic [7:0] d, input bit last, input bit fcs);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = d; rx_last = last; rx_fcs_ok = fcs;
  endtask

  task automatic idle(input int k);
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (k) @(posedge clk);
  endtask

  task automatic send(input logic [47:0] da, input int n, input bit fcs, input int pre,
                      input logic [7:0] sfd, input bit thr, input bit stall, input string tag);
    bit e;
    e = model_err(da, n, fcs, thr);
    if (pre >= 7 && sfd == 8'hD5)
      for (int i = 0; i < n; i++) begin
        exp_q.push_back({i == 0, i == n - 1, (i == n - 1) && e, fbyte(da, i)});
        tag_q.push_back(tag);
      end
    for (int i = 0; i < pre; i++) drive(8'h55, 1'b0, 1'b1);
    drive(sfd, 1'b0, 1'b1);
    for (int i = 0; i < n; i++) begin
      if (stall && i % 5 == 2) begin
        @(posedge clk); #1; rx_valid = 1'b0;
      end
      drive(fbyte(da, i), i == n - 1, fcs);
    end
    idle(4);
  endtask

  task automatic do_reset;
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
  endtask

  task automatic drain(input string tag);
    idle(3);
    vecs++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL %s: %0d bytes missing, expected 0", tag, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    vecs++;
    if ({o_valid, o_sof, o_eof, o_err} !== 4'b0) begin
      bad++;
      $display("FAIL R11 reset outputs: got %b expected 0000", {o_valid, o_sof, o_eof, o_err});
    end
    // R2 R4: matching unicast
    send(stn_addr, 64, 1, 7, 8'hD5, 0, 0, "R2 unicast match");
    send(48'h0A1B2C3D4E50, 64, 1, 7, 8'hD5, 0, 0, "R4 unicast mismatch");
    filt_en = 1'b0;
    send(48'h0A1B2C3D4E50, 80, 1, 7, 8'hD5, 0, 0, "R4 filter off");
    filt_en = 1'b1;
    send(48'h01005E000001, 70, 1, 8, 8'hD5, 0, 0, "R3 group address");
    send(48'hFFFFFFFFFFFF, 64, 1, 7, 8'hD5, 0, 0, "R5 broadcast");
    send(48'hFFFFFFFFFFFE, 64, 1, 7, 8'hD5, 0, 0, "R4 near broadcast");
    send(stn_addr, 63, 1, 7, 8'hD5, 0, 0, "R6 runt 63");
    send(stn_addr, 5, 1, 7, 8'hD5, 0, 0, "R6 runt in address");
    send(stn_addr, 1518, 1, 7, 8'hD5, 0, 0, "R7 std max");
    send(stn_addr, 1519, 1, 7, 8'hD5, 0, 0, "R7 std over");
    jumbo_en = 1'b1;
    send(stn_addr, 1519, 1, 7, 8'hD5, 0, 0, "R7 jumbo 1519");
    send(stn_addr, 9600, 1, 7, 8'hD5, 0, 0, "R7 jumbo max");
    send(stn_addr, 9601, 1, 7, 8'hD5, 0, 0, "R7 jumbo over");
    jumbo_en = 1'b0;
    send(stn_addr, 100, 0, 7, 8'hD5, 0, 0, "R8 bad fcs");
    send(stn_addr, 64, 1, 5, 8'hD5, 0, 0, "R1 short preamble");
    send(stn_addr, 64, 1, 7, 8'hD4, 0, 0, "R1 wrong delimiter");
    send(stn_addr, 64, 1, 7, 8'hD5, 0, 0, "R1 recovery");
    send(stn_addr, 90, 1, 7, 8'hD5, 0, 1, "R10 stalled input");
    drain("R10 all bytes out");
    // R9: broadcast cap
    do_reset();
    bc_lim_en = 1'b1; bc_max = 8'd1; bc_win = 16'd1000;
    send(48'hFFFFFFFFFFFF, 64, 1, 7, 8'hD5, 0, 0, "R9 first broadcast");
    send(48'hFFFFFFFFFFFF, 64, 1, 7, 8'hD5, 1, 0, "R9 capped broadcast");
    send(stn_addr, 64, 1, 7, 8'hD5, 0, 0, "R9 unicast unaffected");
    idle(1100);
    send(48'hFFFFFFFFFFFF, 64, 1, 7, 8'hD5, 0, 0, "R9 next window");
    bc_lim_en = 1'b0;
    send(48'hFFFFFFFFFFFF, 64, 1, 7, 8'hD5, 0, 0, "R9 cap off");
    drain("R9 all bytes out");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule